// File: doc/BRIEF.md
# Path RDI Code Generator

This block produces the three-bit path remote defect indication field carried in the path overhead status byte, one field for each STS-1 channel of a SONET/SDH transmit path. Each channel takes its receive-side path defect flags (alarm indication, loss of pointer, payload label mismatch, unequipped, trace identifier mismatch). A hardware encoder turns these flags into a code, and a per-channel hold timer keeps any raised defect code on the line for a minimum number of frames. An output selector then picks the code to send. The source is the hardware code, a value written by software, or a value supplied by a mate protection board.

Two encodings are available. The legacy encoding reacts only to server-layer defects. The enhanced encoding separates server, connectivity and payload defects. Each defect kind can be masked out of the hardware code. In STS-3 operation all channels carry independent codes. In STM-1 operation only the first channel carries a path, and the remaining channel fields are driven to zero. Every code change takes effect at a frame strobe, so the field never changes in the middle of a frame.

Top module: `rdi_path_gen`

## Requirements
- R1: While reset is asserted and after its release, before the first frame strobe, every channel field of `rdi_code_o` is 000.
- R2: `rdi_code_o` changes only on the clock edge that samples `frame_i` high. The new value appears one cycle after the strobe is sampled.
- R3: With `prot_sel_i`=0 and `sw_mode_i`=1, each channel field takes the software value `sw_code_i[3c+2:3c]`.
- R4: With `stm1_mode_i`=1, the fields of channels 1 and above are 000 whatever the source. Channel 0 uses its own software, protection or hardware code.
- R5: Legacy hardware encoding (`enh_mode_i`=0) gives 100 when an unmasked AIS or LOP flag is present. Otherwise it gives 000. PLM, UNEQ and TIM have no effect in this encoding.
- R6: Enhanced hardware encoding (`enh_mode_i`=1) follows a priority order. AIS or LOP gives 101. Failing that, UNEQ or TIM gives 110. Failing that, PLM gives 010. With no defect the code is 001.
- R7: After the last strobe at which a defect code was raised, the code stays for 19 further strobes. It reverts to the no-defect code at the 20th.
- R8: A defect present at a strobe always sets its own code at once and restarts the hold. This holds even if a different code is being held, or if the hold would expire at that same strobe.
- R9: `inh_mask_i` bits suppress a defect kind in every channel: bit0 AIS, bit1 LOP, bit2 PLM, bit3 UNEQ, bit4 TIM. A masked defect is treated as absent.
- R10: With `prot_sel_i`=1 each channel field takes `prot_code_i[3c+2:3c]`. The protection source has priority over both the software and the hardware source.
- R11: The hardware encoder and hold timer keep running while the software or protection source is selected. On return to hardware the field shows the code the timer holds at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | One-cycle frame strobe |
| sw_mode_i | input | 1 | 1: software code source |
| enh_mode_i | input | 1 | 1: enhanced encoding, 0: legacy |
| stm1_mode_i | input | 1 | 1: single-path STM-1 operation |
| prot_sel_i | input | 1 | 1: take codes from the protection board |
| ais_i | input | NUM_CH | Per-channel AIS flag |
| lop_i | input | NUM_CH | Per-channel loss-of-pointer flag |
| plm_i | input | NUM_CH | Per-channel payload label mismatch flag |
| uneq_i | input | NUM_CH | Per-channel unequipped flag |
| tim_i | input | NUM_CH | Per-channel trace mismatch flag |
| inh_mask_i | input | 5 | Defect inhibit mask (see R9) |
| sw_code_i | input | 3*NUM_CH | Software codes, channel c at [3c+2:3c] |
| prot_code_i | input | 3*NUM_CH | Protection-board codes, channel c at [3c+2:3c] |
| rdi_code_o | output | 3*NUM_CH | Code field per channel, channel c at [3c+2:3c] |

## Verification
Two events can fall on the same frame strobe: a new defect arriving and the expiry of the hold timer. The bench raises PLM for one strobe and then raises AIS exactly 20 strobes later, the strobe at which the PLM hold would lapse. The result is judged correct only if the field goes straight to 101, with no single-frame no-defect code between, and then stays for a further 19 strobes. A second collision is a source switch back to hardware while a hold is still running. The bench counts the strobes in its reference model to check that the held code, and not the idle code, comes out.

// File: rtl/rdi_gen_pkg.sv
package rdi_gen_pkg;
   localparam int CODE_W = 3;
   typedef logic [CODE_W-1:0] rdi_code_t;

   // bit0 ais, bit1 lop, bit2 plm, bit3 uneq, bit4 tim
   typedef struct packed {
      logic tim;
      logic uneq;
      logic plm;
      logic lop;
      logic ais;
   } path_defects_t;

   localparam rdi_code_t LEG_IDLE   = 3'b000;
   localparam rdi_code_t LEG_SERVER = 3'b100;
   localparam rdi_code_t ENH_IDLE   = 3'b001;
   localparam rdi_code_t ENH_SERVER = 3'b101;
   localparam rdi_code_t ENH_CONN   = 3'b110;
   localparam rdi_code_t ENH_PAYLD  = 3'b010;
endpackage

// File: rtl/rdi_defect_encode.sv
module rdi_defect_encode
   import rdi_gen_pkg::*;
(
   input  path_defects_t flags_i,
   input  path_defects_t inhibit_i,
   input  logic          enh_i,
   output rdi_code_t     code_o,
   output logic          active_o
);
   path_defects_t live;
   logic server, conn, payld;

   always_comb begin
      live   = flags_i & ~inhibit_i;
      server = live.ais | live.lop;
      conn   = live.uneq | live.tim;
      payld  = live.plm;
      if (enh_i) begin
         active_o = server | conn | payld;
         if (server)     code_o = ENH_SERVER;
         else if (conn)  code_o = ENH_CONN;
         else if (payld) code_o = ENH_PAYLD;
         else            code_o = ENH_IDLE;
      end else begin
         active_o = server;
         code_o   = server ? LEG_SERVER : LEG_IDLE;
      end
   end
endmodule

// File: rtl/rdi_hold_timer.sv
module rdi_hold_timer
   import rdi_gen_pkg::*;
#(
   parameter int HOLD_FRAMES = 20
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      frame_i,
   input  logic      active_i,
   input  rdi_code_t code_i,
   output rdi_code_t next_code_o
);
   localparam int CNT_W = (HOLD_FRAMES > 2) ? $clog2(HOLD_FRAMES) : 1;
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_FRAMES - 1);

   rdi_code_t        held_q;
   logic [CNT_W-1:0] left_q, left_d;

   always_comb begin
      if (active_i) begin
         next_code_o = code_i;
         left_d      = RELOAD;
      end else if (left_q != '0) begin
         next_code_o = held_q;
         left_d      = left_q - CNT_W'(1);
      end else begin
         next_code_o = code_i;
         left_d      = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= '0;
         left_q <= '0;
      end else if (frame_i) begin
         held_q <= next_code_o;
         left_q <= left_d;
      end
   end
endmodule

// File: rtl/rdi_src_select.sv
module rdi_src_select
   import rdi_gen_pkg::*;
#(
   parameter bit FIRST_CH = 1'b1
) (
   input  logic      stm1_i,
   input  logic      prot_sel_i,
   input  logic      sw_mode_i,
   input  rdi_code_t prot_code_i,
   input  rdi_code_t sw_code_i,
   input  rdi_code_t hw_code_i,
   output rdi_code_t code_o
);
   rdi_code_t picked;

   always_comb begin
      if (prot_sel_i)     picked = prot_code_i;
      else if (sw_mode_i) picked = sw_code_i;
      else                picked = hw_code_i;
   end

   generate
      if (FIRST_CH) begin : g_first
         assign code_o = picked;
      end else begin : g_other
         assign code_o = stm1_i ? rdi_code_t'(0) : picked;
      end
   endgenerate
endmodule

// File: rtl/rdi_path_gen.sv
module rdi_path_gen
   import rdi_gen_pkg::*;
#(
   parameter int NUM_CH      = 3,
   parameter int HOLD_FRAMES = 20
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     frame_i,
   input  logic                     sw_mode_i,
   input  logic                     enh_mode_i,
   input  logic                     stm1_mode_i,
   input  logic                     prot_sel_i,
   input  logic [NUM_CH-1:0]        ais_i,
   input  logic [NUM_CH-1:0]        lop_i,
   input  logic [NUM_CH-1:0]        plm_i,
   input  logic [NUM_CH-1:0]        uneq_i,
   input  logic [NUM_CH-1:0]        tim_i,
   input  logic [4:0]               inh_mask_i,
   input  logic [CODE_W*NUM_CH-1:0] sw_code_i,
   input  logic [CODE_W*NUM_CH-1:0] prot_code_i,
   output logic [CODE_W*NUM_CH-1:0] rdi_code_o
);
   localparam int BUS_W = CODE_W * NUM_CH;

   generate
      if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_ch
         $error("rdi_path_gen: NUM_CH out of range");
      end
      if (HOLD_FRAMES < 2) begin : g_bad_hold
         $error("rdi_path_gen: HOLD_FRAMES must be at least 2");
      end
   endgenerate

   path_defects_t mask;
   assign mask = path_defects_t'(inh_mask_i);

   logic [BUS_W-1:0] next_bus;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      path_defects_t flags;
      rdi_code_t     enc_code, hw_code, sel_code;
      logic          enc_active;

      always_comb begin
         flags.ais  = ais_i[c];
         flags.lop  = lop_i[c];
         flags.plm  = plm_i[c];
         flags.uneq = uneq_i[c];
         flags.tim  = tim_i[c];
      end

      rdi_defect_encode u_enc (
         .flags_i   (flags),
         .inhibit_i (mask),
         .enh_i     (enh_mode_i),
         .code_o    (enc_code),
         .active_o  (enc_active)
      );

      rdi_hold_timer #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
         .clk         (clk),
         .rst_n       (rst_n),
         .frame_i     (frame_i),
         .active_i    (enc_active),
         .code_i      (enc_code),
         .next_code_o (hw_code)
      );

      rdi_src_select #(.FIRST_CH(c == 0)) u_sel (
         .stm1_i      (stm1_mode_i),
         .prot_sel_i  (prot_sel_i),
         .sw_mode_i   (sw_mode_i),
         .prot_code_i (prot_code_i[CODE_W*c +: CODE_W]),
         .sw_code_i   (sw_code_i[CODE_W*c +: CODE_W]),
         .hw_code_i   (hw_code),
         .code_o      (sel_code)
      );

      assign next_bus[CODE_W*c +: CODE_W] = sel_code;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rdi_code_o <= '0;
      else if (frame_i) rdi_code_o <= next_bus;
   end
endmodule

// File: rtl/rdi_gen_checker.sv
module rdi_gen_checker #(
   parameter int NUM_CH = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                frame_i,
   input logic                sw_mode_i,
   input logic                enh_mode_i,
   input logic                stm1_mode_i,
   input logic                prot_sel_i,
   input logic                ais0_i,
   input logic                lop0_i,
   input logic [1:0]          inh_srv_i,
   input logic [2:0]          sw_code0_i,
   input logic [2:0]          prot_code0_i,
   input logic [3*NUM_CH-1:0] rdi_code_o
);
   logic srv0;
   assign srv0 = (ais0_i & ~inh_srv_i[0]) | (lop0_i & ~inh_srv_i[1]);

   // R2
   a_r2_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_i |=> $stable(rdi_code_o));

   // R3
   a_r3_sw_source: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_i && !prot_sel_i && sw_mode_i) |=> rdi_code_o[2:0] == $past(sw_code0_i));

   // R10
   a_r10_prot_source: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_i && prot_sel_i) |=> rdi_code_o[2:0] == $past(prot_code0_i));

   // R5
   a_r5_legacy_server: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_i && !prot_sel_i && !sw_mode_i && !enh_mode_i && srv0) |=> rdi_code_o[2:0] == 3'b100);

   // R6
   a_r6_enh_server: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_i && !prot_sel_i && !sw_mode_i && enh_mode_i && srv0) |=> rdi_code_o[2:0] == 3'b101);

   generate
      if (NUM_CH > 1) begin : g_multi
         // R4
         a_r4_stm1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_i && stm1_mode_i) |=> rdi_code_o[3*NUM_CH-1:3] == '0);
      end
   endgenerate
endmodule

bind rdi_path_gen rdi_gen_checker #(.NUM_CH(NUM_CH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frame_i      (frame_i),
   .sw_mode_i    (sw_mode_i),
   .enh_mode_i   (enh_mode_i),
   .stm1_mode_i  (stm1_mode_i),
   .prot_sel_i   (prot_sel_i),
   .ais0_i       (ais_i[0]),
   .lop0_i       (lop_i[0]),
   .inh_srv_i    (inh_mask_i[1:0]),
   .sw_code0_i   (sw_code_i[2:0]),
   .prot_code0_i (prot_code_i[2:0]),
   .rdi_code_o   (rdi_code_o)
);

// File: tb/tb_rdi_path_gen.sv
module tb_rdi_path_gen;
   localparam int CLK_PERIOD = 10;
   localparam int NCH  = 3;
   localparam int HOLD = 20;
   localparam int GAP  = 4;

   logic clk = 0, rst_n = 0, frame = 0;
   logic sw_mode = 0, enh = 1, stm1 = 0, prot = 0;
   logic [NCH-1:0] ais = 0, lop = 0, plm = 0, uneq = 0, tim = 0;
   logic [4:0] inh = 0;
   logic [3*NCH-1:0] sw_code = 0, prot_code = 0, out;

   int checks = 0, errors = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   rdi_path_gen #(.NUM_CH(NCH), .HOLD_FRAMES(HOLD)) dut (
      .clk(clk), .rst_n(rst_n), .frame_i(frame), .sw_mode_i(sw_mode),
      .enh_mode_i(enh), .stm1_mode_i(stm1), .prot_sel_i(prot),
      .ais_i(ais), .lop_i(lop), .plm_i(plm), .uneq_i(uneq), .tim_i(tim),
      .inh_mask_i(inh), .sw_code_i(sw_code), .prot_code_i(prot_code),
      .rdi_code_o(out));

   // frame strobe: one cycle in GAP
   int fc = 0;
   always @(negedge clk) begin
      fc    = (fc + 1) % GAP;
      frame = (fc == GAP-1);
   end

   // behavioural reference model
   int m_held[NCH], m_left[NCH], m_out[NCH];
   logic last_frame = 0;
   always @(posedge clk) begin
      last_frame = frame;
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin m_held[c] = 0; m_left[c] = 0; m_out[c] = 0; end
      end else if (frame) begin
         for (int c = 0; c < NCH; c++) begin
            bit a, u, p;
            int d;
            a = (ais[c] && !inh[0]) || (lop[c] && !inh[1]);
            p = plm[c] && !inh[2];
            u = (uneq[c] && !inh[3]) || (tim[c] && !inh[4]);
            if (enh) d = a ? 5 : u ? 6 : p ? 2 : -1;
            else     d = a ? 4 : -1;
            if (d >= 0) begin m_held[c] = d; m_left[c] = HOLD - 1; end
            else if (m_left[c] > 0) m_left[c]--;
            else m_held[c] = enh ? 1 : 0;
            if (stm1 && c > 0) m_out[c] = 0;
            else if (prot)     m_out[c] = int'(prot_code[3*c +: 3]);
            else if (sw_mode)  m_out[c] = int'(sw_code[3*c +: 3]);
            else               m_out[c] = m_held[c];
         end
      end
   end

   // compare every clock, away from the active edge
   logic [3*NCH-1:0] prev_out = 0;
   always @(negedge clk) begin
      logic [3*NCH-1:0] exp_v;
      for (int c = 0; c < NCH; c++) exp_v[3*c +: 3] = 3'(m_out[c]);
      checks++;
      if (out !== exp_v) begin
         errors++;
         $display("FAIL %s: rdi_code_o=%b expected %b at %0t", cur_req, out, exp_v, $time);
      end
      if (rst_n && !last_frame) begin
         checks++;
         if (out !== prev_out) begin
            errors++;
            $display("FAIL R2: changed without strobe, actual %b expected %b", out, prev_out);
         end
      end
      prev_out = out;
   end

   task automatic chk(string req, logic [2:0] act, logic [2:0] exp_v);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp_v);
      end
   endtask

   task automatic frames(int n);
      repeat (n * GAP) @(negedge clk);
   endtask

   task automatic clear_defects();
      ais = 0; lop = 0; plm = 0; uneq = 0; tim = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      chk("R1", out[2:0], 3'b000);
      chk("R1", out[8:6], 3'b000);
      rst_n = 1;
      frames(25);
      cur_req = "R6";
      chk("R6", out[2:0], 3'b001);

      // R7: single-strobe AIS, hold of 20 strobes
      cur_req = "R7";
      ais[0] = 1; uneq[1] = 1; plm[2] = 1;
      frames(1); clear_defects();
      chk("R6", out[5:3], 3'b110);
      chk("R6", out[8:6], 3'b010);
      frames(HOLD - 1);
      chk("R7", out[2:0], 3'b101);
      frames(1);
      chk("R7", out[2:0], 3'b001);

      // R6 priority
      cur_req = "R6";
      ais = 3'b001; uneq = 3'b011; plm = 3'b111; tim = 3'b100;
      frames(2);
      chk("R6", out[2:0], 3'b101);
      chk("R6", out[5:3], 3'b110);
      chk("R6", out[8:6], 3'b110);
      clear_defects(); frames(HOLD + 2);

      // R8: collision of new defect with hold expiry
      cur_req = "R8";
      plm[0] = 1; frames(1); plm[0] = 0;
      frames(HOLD - 1);
      ais[0] = 1; frames(1); ais[0] = 0;
      chk("R8", out[2:0], 3'b101);
      frames(HOLD - 1);
      chk("R8", out[2:0], 3'b101);
      frames(1);
      chk("R8", out[2:0], 3'b001);
      plm[1] = 1; frames(3); plm[1] = 0; uneq[1] = 1; frames(1); uneq[1] = 0;
      chk("R8", out[5:3], 3'b110);
      frames(HOLD + 1);

      // R5 legacy
      cur_req = "R5"; enh = 0;
      frames(2);
      chk("R5", out[2:0], 3'b000);
      plm = 3'b111; uneq = 3'b111; tim = 3'b111; frames(3);
      chk("R5", out[2:0], 3'b000);
      lop[2] = 1; frames(1); clear_defects();
      chk("R5", out[8:6], 3'b100);
      frames(HOLD + 1);

      // R9 masks
      cur_req = "R9"; enh = 1; inh = 5'b00001;
      ais = 3'b111; lop = 3'b010; frames(2);
      chk("R9", out[2:0], 3'b001);
      chk("R9", out[5:3], 3'b101);
      inh = 5'b11111; plm = 3'b111; uneq = 3'b111; tim = 3'b111; frames(2);
      chk("R9", out[2:0], 3'b001);
      clear_defects(); inh = 0; frames(HOLD + 1);

      // R3 software, R11 timer runs behind it
      cur_req = "R3"; sw_mode = 1; sw_code = 9'b011_110_111;
      uneq[0] = 1; frames(1); uneq[0] = 0;
      chk("R3", out[2:0], 3'b111);
      chk("R3", out[8:6], 3'b011);
      frames(5);
      cur_req = "R11"; sw_mode = 0; frames(1);
      chk("R11", out[2:0], 3'b110);
      frames(HOLD);

      // R10 protection
      cur_req = "R10"; prot = 1; sw_mode = 1; prot_code = 9'b101_010_100;
      ais = 3'b111; frames(2); clear_defects();
      chk("R10", out[2:0], 3'b100);
      chk("R10", out[5:3], 3'b010);

      // R4 STM-1
      cur_req = "R4"; stm1 = 1; frames(2);
      chk("R4", out[5:3], 3'b000);
      chk("R4", out[2:0], 3'b100);
      prot = 0; frames(2);
      chk("R4", out[2:0], 3'b111);
      sw_mode = 0; ais = 3'b111; frames(2);
      chk("R4", out[8:6], 3'b000);
      clear_defects(); stm1 = 0; frames(HOLD + 1);

      // mixed pattern, compared every clock
      cur_req = "R8";
      for (int i = 0; i < 300; i++) begin
         ais  = 3'($urandom() & ($urandom() & 7));
         lop  = 3'($urandom() & ($urandom() & 7));
         plm  = 3'($urandom());
         uneq = 3'($urandom() & ($urandom() & 7));
         tim  = 3'($urandom() & ($urandom() & 7));
         if (($urandom() % 8) == 0) inh = 5'($urandom());
         if (($urandom() % 16) == 0) enh = ~enh;
         sw_mode = (($urandom() % 10) == 0);
         prot    = (($urandom() % 12) == 0);
         stm1    = (($urandom() % 14) == 0);
         sw_code = 9'($urandom()); prot_code = 9'($urandom());
         frames(1 + int'($urandom() % 3));
         if (($urandom() % 4) != 0) clear_defects();
      end

      frames(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule